// File: doc/BRIEF.md
# PCM Voice Register Window

This block sits between a host bus and a multi-voice PCM playback engine. The host sees a byte-wide window. The lower 32 offsets are the live voice registers: a write there is stored and also passed on to the engine one cycle later, and a read there is forwarded to the engine. The next 32 offsets form a shadow region. A read there returns the byte last stored for the matching live register. A write there only updates that stored byte and never reaches the engine.

One offset in the shadow region, 0x21, is repurposed as a sample probe. Reading it builds a sample memory address from the staged start-address bytes and the bank byte. That address is sent to the sample memory, and the byte read back is returned to the host. The address is also copied into four debug bytes at 0x40..0x43, most significant byte first, so software can check what was fetched. To keep the map symmetric, offset 0x01 takes over the shadow role that 0x21 gave up.

Every read, whatever its target, completes exactly one cycle after the request. At that point the block raises a read-valid pulse.

Top module: `pcm_voice_regwin`

## Requirements
- R1: After reset every stored byte, every debug byte, `voice_mask`, `voice_sel`, `rd_valid`, `eng_we`, `eng_re` and `rom_re` are zero.
- R2: A host write at offset 0x00..0x1F stores the byte. In the following cycle the block asserts `eng_we` for one cycle, with `eng_waddr` equal to the offset and `eng_wdata` equal to the byte.
- R3: A host write at offset 0x20..0x3F stores the byte under offset minus 0x20 and never asserts `eng_we`.
- R4: A host read at 0x00 or at 0x02..0x1F asserts `eng_re` in the request cycle with `eng_raddr` equal to the offset. The byte the engine returns on `eng_rdata` one cycle later is presented on `rdata`.
- R5: A host read at 0x01, or at 0x20..0x3F other than 0x21, returns the stored byte for offset modulo 0x20.
- R6: A host read at 0x21 asserts `rom_re` with `rom_addr` set to the following value, and returns the sample memory byte from `rom_rdata` one cycle later:
  - S = {byte 0x0B, byte 0x0A, byte 0x09}, with 0x09 as the least significant byte.
  - `rom_addr` = (((S >> 6) + 2) mod 2^18) OR (byte 0x03 << 16).
- R7: Each sample probe writes the probe address, zero-extended to 32 bits, into debug bytes 0x40..0x43, with the most significant byte at 0x40. Host reads at 0x40..0x43 return those bytes.
- R8: Host writes at 0x40 and above change nothing, and host reads at 0x44 and above return zero.
- R9: `voice_mask` is {byte 0x17, byte 0x15, byte 0x13, byte 0x11}, and `voice_sel` is byte 0x1F.
- R10: `rd_valid` is high exactly in the cycle after each cycle in which `rd_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte offset |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| eng_we | output | 1 | Register write to voice engine |
| eng_waddr | output | 5 | Engine register index for write |
| eng_wdata | output | 8 | Engine write byte |
| eng_re | output | 1 | Register read request to voice engine |
| eng_raddr | output | 5 | Engine register index for read |
| eng_rdata | input | 8 | Engine read byte, one cycle after eng_re |
| rom_re | output | 1 | Sample memory read request |
| rom_addr | output | 24 | Sample memory byte address |
| rom_rdata | input | 8 | Sample memory byte, one cycle after rom_re |
| voice_mask | output | 32 | Voice enable mask |
| voice_sel | output | 8 | Selected voice |

## Verification
The hardest case to reach is a sample probe whose bank byte overlaps bits 16 and 17 of the masked start address, combined with a +2 that carries past bit 17 and must be discarded. Both effects occur only for start bytes near all-ones together with a bank value that has its low bits set. The stimulus reaches this case by staging the start bytes through shadow-region writes, which keep the engine quiet. It then probes at 0x21 and reads the four debug bytes back, so the discarded carry and the OR-merged bank bits are both visible at the ports.

// File: rtl/pcm_voice_regwin.sv
module pcm_voice_regwin #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NREG = 32,
  parameter int ROM_AW = 24,
  parameter int START_SHIFT = 6,
  parameter int ADDR_BIAS = 2,
  parameter int ADDR_KEEP = 18,
  parameter int BANK_LSB = 16,
  parameter int DBG_N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic                      rd_valid,
  output logic                      eng_we,
  output logic [$clog2(NREG)-1:0]   eng_waddr,
  output logic [DW-1:0]             eng_wdata,
  output logic                      eng_re,
  output logic [$clog2(NREG)-1:0]   eng_raddr,
  input  logic [DW-1:0]             eng_rdata,
  output logic                      rom_re,
  output logic [ROM_AW-1:0]         rom_addr,
  input  logic [DW-1:0]             rom_rdata,
  output logic [4*DW-1:0]           voice_mask,
  output logic [DW-1:0]             voice_sel
);
  localparam int RIW = $clog2(NREG);
  localparam int SRC_W = 3 * DW;
  localparam int DBG_W = DBG_N * DW;
  localparam logic [AW-1:0] SHADOW_LO = AW'(NREG);
  localparam logic [AW-1:0] DBG_LO = AW'(2 * NREG);
  localparam logic [AW-1:0] DBG_HI = AW'(2 * NREG + DBG_N);
  localparam logic [AW-1:0] PROBE_OFF = AW'(NREG + 1);
  localparam logic [AW-1:0] SWAP_OFF = AW'(1);
  localparam int BANK_IDX = 3;
  localparam int START_IDX = 9;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] dbg [DBG_N];
  logic [1:0]    src_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] hold_d;
  logic [DW-1:0] bank_b;
  logic [SRC_W-1:0] start_w;
  logic [SRC_W-1:0] stepped;
  logic [DBG_W-1:0] dbg_word;

  wire probe_hit  = addr == PROBE_OFF;
  wire eng_hit    = addr < SHADOW_LO && addr != SWAP_OFF;
  wire store_hit  = (addr >= SHADOW_LO && addr < DBG_LO && !probe_hit) || addr == SWAP_OFF;
  wire dbg_hit    = addr >= DBG_LO && addr < DBG_HI;
  wire store_wr   = wr_en && addr < DBG_LO;

  assign bank_b   = regs[BANK_IDX];
  assign start_w  = {regs[START_IDX+2], regs[START_IDX+1], regs[START_IDX]};
  assign stepped  = (start_w >> START_SHIFT) + SRC_W'(ADDR_BIAS);
  assign rom_addr = {{(ROM_AW-ADDR_KEEP){1'b0}}, stepped[ADDR_KEEP-1:0]}
                  | (ROM_AW'(bank_b) << BANK_LSB);
  assign dbg_word = DBG_W'(rom_addr);

  assign eng_re    = rd_en && eng_hit;
  assign eng_raddr = addr[RIW-1:0];
  assign rom_re    = rd_en && probe_hit;

  assign voice_mask = {regs[5'h17], regs[5'h15], regs[5'h13], regs[5'h11]};
  assign voice_sel  = regs[5'h1F];

  always_comb begin
    hold_d = '0;
    if (store_hit) hold_d = regs[addr[RIW-1:0]];
    else if (dbg_hit) hold_d = dbg[addr[$clog2(DBG_N)-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      for (int k = 0; k < DBG_N; k++) dbg[k] <= '0;
      src_q     <= '0;
      hold_q    <= '0;
      rd_valid  <= 1'b0;
      eng_we    <= 1'b0;
      eng_waddr <= '0;
      eng_wdata <= '0;
    end else begin
      if (store_wr) regs[addr[RIW-1:0]] <= wdata;
      if (rom_re)
        for (int k = 0; k < DBG_N; k++) dbg[k] <= dbg_word[(DBG_N-1-k)*DW +: DW];
      eng_we    <= wr_en && addr < SHADOW_LO;
      eng_waddr <= addr[RIW-1:0];
      eng_wdata <= wdata;
      rd_valid  <= rd_en;
      src_q     <= {rom_re, eng_re};
      hold_q    <= hold_d;
    end
  end

  assign rdata = src_q[0] ? eng_rdata : src_q[1] ? rom_rdata : hold_q;
endmodule

// File: rtl/pcm_voice_regwin_chk.sv
module pcm_voice_regwin_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int ROM_AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic              rd_valid,
  input logic              eng_we,
  input logic              eng_re,
  input logic              rom_re,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [DW-1:0]     bank_b
);
  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_engine_write_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> ($past(wr_en) && $past(addr) < 8'h20));
  p_shadow_write_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= 8'h20 && addr < 8'h40) |=> !eng_we);
  p_one_read_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_re, rom_re}));
  p_bank_in_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |-> rom_addr[ROM_AW-1:ROM_AW-6] == bank_b[DW-1:2]);
endmodule

bind pcm_voice_regwin pcm_voice_regwin_chk #(.AW(AW), .DW(DW), .ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_valid(rd_valid), .eng_we(eng_we), .eng_re(eng_re), .rom_re(rom_re),
  .rom_addr(rom_addr), .bank_b(bank_b)
);

// File: tb/pcm_voice_regwin_tb.sv
module pcm_voice_regwin_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic rd_valid, eng_we, eng_re, rom_re;
  logic [4:0] eng_waddr, eng_raddr;
  logic [7:0] eng_wdata, voice_sel;
  logic [7:0] eng_rdata = 0, rom_rdata = 0;
  logic [23:0] rom_addr;
  logic [31:0] voice_mask;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] st [0:31];

  always #5 clk = ~clk;

  pcm_voice_regwin u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .eng_we(eng_we),
    .eng_waddr(eng_waddr), .eng_wdata(eng_wdata), .eng_re(eng_re),
    .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .rom_re(rom_re),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .voice_mask(voice_mask),
    .voice_sel(voice_sel)
  );

  function automatic logic [7:0] rom_f(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic logic [23:0] probe_addr();
    logic [23:0] s;
    logic [23:0] t;
    s = {st[11], st[10], st[9]};
    t = (s >> 6) + 24'd2;
    return {6'd0, t[17:0]} | ({16'd0, st[3]} << 16);
  endfunction

  always @(posedge clk) begin
    if (eng_re) eng_rdata <= {3'b110, eng_raddr};
    if (rom_re) rom_rdata <= rom_f(rom_addr);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    if (a < 8'h40) st[a[4:0]] = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 8'h20) begin
      check("R2 eng_we", {31'd0, eng_we}, 1);
      check("R2 eng addr/data", {19'd0, eng_waddr, eng_wdata}, {19'd0, a[4:0], d});
    end else check("R3/R8 no engine write", {31'd0, eng_we}, 0);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic probe_and_dump(string tag);
    logic [23:0] pa;
    pa = probe_addr();
    rd(8'h21, rom_f(pa), {tag, " R6 probe data"});
    rd(8'h40, 8'h00, {tag, " R7 dbg40"});
    rd(8'h41, pa[23:16], {tag, " R7 dbg41"});
    rd(8'h42, pa[15:8], {tag, " R7 dbg42"});
    rd(8'h43, pa[7:0], {tag, " R7 dbg43"});
  endtask

  initial begin
    fork
      begin
        #1500000;
        check("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    for (int i = 0; i < 32; i++) st[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset voice_mask", voice_mask, 0);
    check("R1 reset voice_sel/rd_valid/eng_we", {voice_sel, rd_valid, eng_we}, 0);
    rd(8'h25, 8'h00, "R1 reset stored byte");
    rd(8'h42, 8'h00, "R1 reset debug byte");

    wr(8'h05, 8'h40);
    wr(8'h04, 8'h00);
    wr(8'h01, 8'h77);
    rd(8'h25, 8'h40, "R5 shadow 0x25");
    rd(8'h01, 8'h77, "R5 swapped 0x01");
    rd(8'h04, 8'hC4, "R4 engine read 0x04");
    rd(8'h1F, 8'hDF, "R4 engine read 0x1F");
    rd(8'h00, 8'hC0, "R4 engine read 0x00");

    wr(8'h11, 8'hA5); wr(8'h13, 8'h5A); wr(8'h15, 8'h3C); wr(8'h17, 8'hC3);
    wr(8'h1F, 8'h12);
    check("R9 voice_mask", voice_mask, 32'hC33C5AA5);
    check("R9 voice_sel", {24'd0, voice_sel}, 32'h12);
    wr(8'h37, 8'h81);
    check("R3 shadow write reaches storage", voice_mask, 32'h813C5AA5);
    rd(8'h37, 8'h81, "R3 shadow write readback");

    wr(8'h03, 8'h38); wr(8'h0B, 8'h01); wr(8'h0A, 8'h23); wr(8'h09, 8'h40);
    check("R6 expected address", {8'd0, probe_addr()}, 32'h0038048F);
    probe_and_dump("basic");

    wr(8'h2B, 8'hFF); wr(8'h2A, 8'hFF); wr(8'h29, 8'hFF);
    check("R6 carry discarded", {8'd0, probe_addr()}, 32'h00380001);
    probe_and_dump("carry");

    wr(8'h23, 8'h3B); wr(8'h2B, 8'h7F); wr(8'h2A, 8'hFF); wr(8'h29, 8'hC0);
    check("R6 bank overlap", {8'd0, probe_addr()}, 32'h003B0001);
    probe_and_dump("overlap");

    wr(8'h41, 8'h99);
    wr(8'h80, 8'h55);
    rd(8'h41, 8'h3B, "R8 write to debug ignored");
    rd(8'h60, 8'h00, "R8 high offset reads zero");
    rd(8'h44, 8'h00, "R8 offset 0x44 reads zero");

    @(negedge clk);
    check("R10 every read answered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule